// File: doc/BRIEF.md
# External Interrupt Trigger Latch Unit

This unit watches up to eight external interrupt request lines and one non-maskable request line for a small microcontroller core. Every request line passes through a two-flop synchronizer and is then judged against a trigger mode that software picks per line: held low, falling edge, rising edge or either edge. A detected trigger sets a per-line flag. A flag whose enable bit is also set becomes a pending request. The lowest-numbered pending line is presented on `irq_req` together with its index.

Software reaches the unit through a byte-wide register port. It has five registers: line enable, two trigger-select bytes, line flags and system control. Flags are cleared by an AND-style write. A line in low-level mode that is still held low latches again immediately, both after a clear and after a mode change.

The non-maskable line has its own edge latch. The active edge comes from the system control byte. The latch is released by `nmi_ack` and pays no attention to the enable byte. The `HAS_STATUS` parameter builds a lighter variant that has no readable flag register. In that variant a flag lives only for the cycle in which it is presented, and low-level lines are re-evaluated on every cycle.

Top module: `ext_irq_latch`

## Requirements
- R1: After reset, every register reads 0, `irq_req` and `nmi_req` are 0, every line is in low-level mode and the non-maskable edge is falling.
- R2: Each line has a 2-bit trigger code. Line i uses bits 2i+1:2i of address 1 for lines 0-3, and bits 2(i-4)+1:2(i-4) of address 2 for lines 4-7. Code 0 = input low, 1 = falling edge, 2 = rising edge, 3 = either edge.
- R3: A change on a request input becomes visible in the flags on the third rising clock edge after it is applied, and not earlier.
- R4: A write to address 3 ANDs the written byte into the flags: a 0 bit clears the flag and a 1 bit keeps it. A detection in the same cycle as a clearing write leaves the flag set. A flag is never set without a detection.
- R5: A line in low-level mode whose input is still low sets its flag again on the cycle after a clear. A line switched into low-level mode while its input is low sets its flag on the cycle after the write.
- R6: A line is pending only when its flag and its enable bit (address 0, bit i) are both 1. `irq_req` is 1 exactly when some line is pending.
- R7: When several lines are pending, `irq_idx` gives the lowest-numbered one.
- R8: The non-maskable edge is rising when system control (address 4) bit 2 is 1, and falling when it is 0. A detected edge sets `nmi_req`. `nmi_ack` clears it, a detection in the same cycle wins over the acknowledge, and the enable register has no effect on it.
- R9: With `HAS_STATUS` = 0, address 3 reads 0 and writes to it have no effect. Each flag equals the detection of the previous cycle, so an edge gives a one-cycle request and a held-low low-level line keeps requesting.
- R10: Addresses 0, 1, 2 and 4 read back the last byte written to them. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | NUM_LINES | External request lines, asynchronous |
| nmi_in | input | 1 | Non-maskable request line, asynchronous |
| nmi_ack | input | 1 | Clears the non-maskable latch |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| irq_req | output | 1 | Some line is pending |
| irq_idx | output | IDX_W | Index of the lowest pending line |
| nmi_req | output | 1 | Non-maskable request latched |

## Verification
The collision that matters most is a clearing write to the flag register landing in the same cycle as a fresh detection on the same line. The bench times a rising edge so that its detection cycle lines up with a write of 0 to the flag byte, and expects the flag to survive while an older flag in the same write is cleared. The same collision between `nmi_ack` and a new non-maskable edge is reached in the randomised phase. There, a cycle-by-cycle reference model judges every output of both variants.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_FALL = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_BOTH = 2'd3
  } trig_e;

  localparam logic [2:0] ADDR_ENABLE  = 3'd0;
  localparam logic [2:0] ADDR_TRIG_LO = 3'd1;
  localparam logic [2:0] ADDR_TRIG_HI = 3'd2;
  localparam logic [2:0] ADDR_FLAGS   = 3'd3;
  localparam logic [2:0] ADDR_SYSCTL  = 3'd4;

  localparam int NMI_EDGE_BIT = 2;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int   W       = 1,
  parameter logic IDLE    = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;
  logic [W-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {W{IDLE}};
      stab_q <= {W{IDLE}};
      hist_q <= {W{IDLE}};
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
      hist_q <= stab_q;
    end
  end

  assign q      = stab_q;
  assign q_prev = hist_q;

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]   cur,
  input  logic [N-1:0]   prev,
  input  logic [2*N-1:0] mode,
  output logic [N-1:0]   hit
);

  for (genvar g = 0; g < N; g++) begin : g_line
    logic h;
    always_comb begin
      case (trig_e'(mode[2*g +: 2]))
        TRIG_LOW:  h = ~cur[g];
        TRIG_FALL: h = prev[g] & ~cur[g];
        TRIG_RISE: h = ~prev[g] & cur[g];
        default:   h = prev[g] ^ cur[g];
      endcase
    end
    assign hit[g] = h;
  end

endmodule

// File: rtl/ext_irq_prio.sv
module ext_irq_prio #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
  import ext_irq_pkg::*;
#(
  parameter int NUM_LINES  = 8,
  parameter bit HAS_STATUS = 1'b1,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 3,
  localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 nmi_in,
  input  logic                 nmi_ack,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 irq_req,
  output logic [IDX_W-1:0]     irq_idx,
  output logic                 nmi_req
);

  localparam int TRIG_W = 2 * DATA_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ns <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ns <= rst_s1;
    end
  end

  // input conditioning
  logic [NUM_LINES-1:0] line_cur, line_prev;
  logic                 nmi_cur, nmi_prev;

  ext_irq_sync #(.W(NUM_LINES), .IDLE(1'b1)) u_line_sync (
    .clk(clk), .rst_n(rst_ns), .d(irq_in), .q(line_cur), .q_prev(line_prev)
  );

  ext_irq_sync #(.W(1), .IDLE(1'b1)) u_nmi_sync (
    .clk(clk), .rst_n(rst_ns), .d(nmi_in), .q(nmi_cur), .q_prev(nmi_prev)
  );

  // architectural state
  logic [DATA_W-1:0]    en_q,   en_d;
  logic [TRIG_W-1:0]    trig_q, trig_d;
  logic [DATA_W-1:0]    sys_q,  sys_d;
  logic [NUM_LINES-1:0] flag_q, flag_d;
  logic                 nmi_q,  nmi_d;

  logic [NUM_LINES-1:0] hit;
  logic                 nmi_hit;
  logic                 st_we;
  logic [NUM_LINES-1:0] keep_mask;

  ext_irq_detect #(.N(NUM_LINES)) u_detect (
    .cur(line_cur), .prev(line_prev), .mode(trig_q[2*NUM_LINES-1:0]), .hit(hit)
  );

  assign nmi_hit = sys_q[NMI_EDGE_BIT] ? (nmi_cur & ~nmi_prev)
                                       : (~nmi_cur & nmi_prev);

  assign st_we     = reg_we && (reg_addr == ADDR_W'(ADDR_FLAGS));
  assign keep_mask = st_we ? reg_wdata[NUM_LINES-1:0] : '1;

  // next state
  always_comb begin
    en_d   = en_q;
    trig_d = trig_q;
    sys_d  = sys_q;
    if (reg_we) begin
      case (reg_addr)
        ADDR_W'(ADDR_ENABLE):  en_d = reg_wdata;
        ADDR_W'(ADDR_TRIG_LO): trig_d[DATA_W-1:0] = reg_wdata;
        ADDR_W'(ADDR_TRIG_HI): trig_d[TRIG_W-1:DATA_W] = reg_wdata;
        ADDR_W'(ADDR_SYSCTL):  sys_d = reg_wdata;
        default: ;
      endcase
    end
    nmi_d = nmi_hit | (nmi_q & ~nmi_ack);
  end

  if (HAS_STATUS) begin : g_status
    assign flag_d = (flag_q & keep_mask) | hit;
  end else begin : g_nostatus
    assign flag_d = hit;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      en_q   <= '0;
      trig_q <= '0;
      sys_q  <= '0;
      flag_q <= '0;
      nmi_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      trig_q <= trig_d;
      sys_q  <= sys_d;
      flag_q <= flag_d;
      nmi_q  <= nmi_d;
    end
  end

  // request presentation
  logic [NUM_LINES-1:0] pending;
  assign pending = flag_q & en_q[NUM_LINES-1:0];

  ext_irq_prio #(.N(NUM_LINES), .IW(IDX_W)) u_prio (
    .req(pending), .any(irq_req), .idx(irq_idx)
  );

  assign nmi_req = nmi_q;

  // read port
  always_comb begin
    case (reg_addr)
      ADDR_W'(ADDR_ENABLE):  reg_rdata = en_q;
      ADDR_W'(ADDR_TRIG_LO): reg_rdata = trig_q[DATA_W-1:0];
      ADDR_W'(ADDR_TRIG_HI): reg_rdata = trig_q[TRIG_W-1:DATA_W];
      ADDR_W'(ADDR_FLAGS):   reg_rdata = HAS_STATUS ? DATA_W'(flag_q) : '0;
      ADDR_W'(ADDR_SYSCTL):  reg_rdata = sys_q;
      default:               reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ext_irq_latch_chk.sv
module ext_irq_latch_chk #(
  parameter int N          = 8,
  parameter bit HAS_STATUS = 1'b1,
  parameter int IW         = 3,
  parameter int DW         = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  flag,
  input logic [N-1:0]  hit,
  input logic [DW-1:0] en,
  input logic [DW-1:0] wdata,
  input logic          st_we,
  input logic          irq_req,
  input logic [IW-1:0] irq_idx,
  input logic          nmi_req,
  input logic          nmi_ack,
  input logic          nmi_hit
);

  logic [N-1:0] pend;
  logic [N-1:0] below;
  assign pend  = flag & en[N-1:0];
  assign below = (N'(1) << irq_idx) - N'(1);

  assert_req_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (flag[irq_idx] && en[irq_idx]));

  assert_idle_when_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (pend == '0));

  assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((pend & below) == '0));

  assert_flag_needs_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag & ~$past(flag) & ~$past(hit)) == '0);

  if (HAS_STATUS) begin : g_st
    assert_clear_applies_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(st_we) |-> ((flag & ~$past(hit) & ~$past(wdata[N-1:0])) == '0));
  end else begin : g_nost
    assert_flag_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flag == $past(hit));
  end

  assert_nmi_needs_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_req) |-> $past(nmi_hit));

  assert_nmi_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ack && !nmi_hit) |=> !nmi_req);

endmodule

bind ext_irq_latch ext_irq_latch_chk #(
  .N(NUM_LINES), .HAS_STATUS(HAS_STATUS), .IW(IDX_W), .DW(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_ns), .flag(flag_q), .hit(hit), .en(en_q),
  .wdata(reg_wdata), .st_we(st_we), .irq_req(irq_req), .irq_idx(irq_idx),
  .nmi_req(nmi_req), .nmi_ack(nmi_ack), .nmi_hit(nmi_hit)
);

// File: tb/sim_ext_irq_latch.sv
module sim_ext_irq_latch;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_in;
  logic       nmi_in, nmi_ack, reg_we;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;

  logic [7:0] rdata0, rdata1;
  logic       req0, req1, nmi0, nmi1;
  logic [2:0] idx0, idx1;

  int checks = 0;
  int fails  = 0;
  bit chk_on = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ext_irq_latch #(.NUM_LINES(8), .HAS_STATUS(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in), .nmi_ack(nmi_ack),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata0),
    .irq_req(req0), .irq_idx(idx0), .nmi_req(nmi0)
  );

  ext_irq_latch #(.NUM_LINES(8), .HAS_STATUS(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in), .nmi_ack(nmi_ack),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata1),
    .irq_req(req1), .irq_idx(idx1), .nmi_req(nmi1)
  );

  // ---------------- reference model ----------------
  logic [7:0]  m_s1, m_s2, m_pv, m_f0, m_f1, m_en, m_sys;
  logic [15:0] m_trig;
  logic        m_n1, m_n2, m_np, m_nl, m_r1, m_r2;

  function automatic logic [7:0] detect(logic [7:0] c, logic [7:0] p, logic [15:0] t);
    logic [7:0] h;
    for (int i = 0; i < 8; i++) begin
      case ((t >> (2 * i)) & 16'd3)
        16'd0:   h[i] = !c[i];
        16'd1:   h[i] = p[i] && !c[i];
        16'd2:   h[i] = !p[i] && c[i];
        default: h[i] = p[i] != c[i];
      endcase
    end
    return h;
  endfunction

  task automatic model_reset();
    m_s1 = 8'hFF; m_s2 = 8'hFF; m_pv = 8'hFF;
    m_f0 = 0; m_f1 = 0; m_en = 0; m_sys = 0; m_trig = 0;
    m_n1 = 1; m_n2 = 1; m_np = 1; m_nl = 0;
  endtask

  initial begin
    model_reset();
    m_r1 = 0; m_r2 = 0;
  end

  always @(posedge clk) begin
    logic [7:0] h;
    logic       nh;
    if (!m_r2 || !rst_n) begin
      model_reset();
    end else begin
      h  = detect(m_s2, m_pv, m_trig);
      nh = m_sys[2] ? (m_n2 && !m_np) : (!m_n2 && m_np);
      m_f0 = (m_f0 & ((reg_we && reg_addr == 3'd3) ? reg_wdata : 8'hFF)) | h;
      m_f1 = h;
      m_nl = nh || (m_nl && !nmi_ack);
      if (reg_we) begin
        if (reg_addr == 3'd0) m_en = reg_wdata;
        if (reg_addr == 3'd1) m_trig[7:0] = reg_wdata;
        if (reg_addr == 3'd2) m_trig[15:8] = reg_wdata;
        if (reg_addr == 3'd4) m_sys = reg_wdata;
      end
      m_pv = m_s2; m_s2 = m_s1; m_s1 = irq_in;
      m_np = m_n2; m_n2 = m_n1; m_n1 = nmi_in;
    end
    m_r2 = rst_n ? m_r1 : 1'b0;
    m_r1 = rst_n;
  end

  function automatic int lowest(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic logic [7:0] model_read(bit variant1);
    case (reg_addr)
      3'd0: return m_en;
      3'd1: return m_trig[7:0];
      3'd2: return m_trig[15:8];
      3'd3: return variant1 ? 8'h00 : m_f0;
      3'd4: return m_sys;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (chk_on) begin
      check("R6 u0 irq_req", req0, |(m_f0 & m_en));
      if (|(m_f0 & m_en)) check("R7 u0 irq_idx", idx0, lowest(m_f0 & m_en));
      check("R8 u0 nmi_req", nmi0, m_nl);
      check("R10 u0 rdata", rdata0, model_read(1'b0));
      check("R9 u1 irq_req", req1, |(m_f1 & m_en));
      if (|(m_f1 & m_en)) check("R9 u1 irq_idx", idx1, lowest(m_f1 & m_en));
      check("R8 u1 nmi_req", nmi1, m_nl);
      check("R9 u1 rdata", rdata1, model_read(1'b1));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [2:0] a, bit variant1, logic [7:0] exp, string tag);
    reg_addr = a;
    #2;
    check(tag, variant1 ? rdata1 : rdata0, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; irq_in = 8'hFF; nmi_in = 1; nmi_ack = 0;
    reg_we = 0; reg_addr = 0; reg_wdata = 0;
    wait_n(5);
    rst_n = 1;
    wait_n(4);
    chk_on = 1;

    // R1 reset state, R10 unused address
    for (int a = 0; a < 8; a++) rd(3'(a), 1'b0, 8'h00, "R1 reset register");
    check("R1 irq_req after reset", req0, 0);
    check("R1 nmi_req after reset", nmi0, 0);

    wr(3'd0, 8'hFF);
    wait_n(1); rd(3'd0, 1'b0, 8'hFF, "R10 enable readback");

    // R3 latency and R2 low-level mode
    @(negedge clk); irq_in[3] = 0;
    wait_n(2); #2 check("R3 no flag after two edges", req0, 0);
    wait_n(1); #2 check("R3 flag on third edge", req0, 1);
    check("R2 low level index", idx0, 3);

    // R5 clear while still low re-latches
    wr(3'd3, 8'h00);
    wait_n(1); rd(3'd3, 1'b0, 8'h08, "R5 relatch after clear");

    @(negedge clk); irq_in[3] = 1;
    wait_n(4); wr(3'd3, 8'h00); wait_n(1);
    rd(3'd3, 1'b0, 8'h00, "R4 write zero clears");
    check("R6 no request after clear", req0, 0);

    // R2 per-line modes: line1 fall, line2 rise, line3 both
    wr(3'd1, 8'hE4);
    wait_n(1); rd(3'd1, 1'b0, 8'hE4, "R10 trigger readback");
    @(negedge clk); irq_in[2] = 0;
    wait_n(4); rd(3'd3, 1'b0, 8'h00, "R2 rising ignores fall");
    @(negedge clk); irq_in[2] = 1;
    wait_n(4); rd(3'd3, 1'b0, 8'h04, "R2 rising edge");
    wr(3'd3, 8'h00);
    @(negedge clk); irq_in[1] = 0; irq_in[3] = 0;
    wait_n(4); rd(3'd3, 1'b0, 8'h0A, "R2 falling and either edge");
    check("R7 lowest pending index", idx0, 1);

    // R6 enable gating
    wr(3'd0, 8'hFD); wait_n(1); #2
    check("R6 disabled line skipped", idx0, 3);
    rd(3'd3, 1'b0, 8'h0A, "R6 flag kept while disabled");
    wr(3'd0, 8'h00); wait_n(1); #2
    check("R6 no enable no request", req0, 0);
    wr(3'd0, 8'hFF);

    // R4 write of one keeps the flag
    wr(3'd3, 8'h08); wait_n(1);
    rd(3'd3, 1'b0, 8'h08, "R4 and-write keeps ones");

    // R5 mode change into low level while held low
    wr(3'd1, 8'hE0); wait_n(1);
    rd(3'd3, 1'b0, 8'h0A, "R5 relatch on mode change");

    wr(3'd1, 8'hE4);
    @(negedge clk); irq_in[1] = 1;
    wait_n(4); wr(3'd3, 8'h00); wait_n(1);
    // line3 (either edge) still low: set it again with a toggle
    @(negedge clk); irq_in[3] = 1;
    wait_n(4); rd(3'd3, 1'b0, 8'h08, "R2 either edge on rise");

    // R4 collision: clearing write in the detection cycle of line2
    @(negedge clk); irq_in[2] = 0;
    wait_n(4);
    @(negedge clk); irq_in[2] = 1;
    @(negedge clk);
    @(negedge clk); reg_addr = 3'd3; reg_wdata = 8'h00; reg_we = 1;
    @(negedge clk); reg_we = 0;
    rd(3'd3, 1'b0, 8'h04, "R4 detection beats clear");

    // R8 non-maskable line, enable cleared to show it has no effect
    wr(3'd0, 8'h00);
    @(negedge clk); nmi_in = 0;
    wait_n(4); #2 check("R8 falling edge latched", nmi0, 1);
    @(negedge clk); nmi_ack = 1;
    @(negedge clk); nmi_ack = 0; #2
    check("R8 ack clears", nmi0, 0);
    @(negedge clk); nmi_in = 1;
    wait_n(4); #2 check("R8 rise ignored in falling mode", nmi0, 0);
    wr(3'd4, 8'h04); wait_n(1);
    rd(3'd4, 1'b0, 8'h04, "R10 sysctl readback");
    @(negedge clk); nmi_in = 0;
    wait_n(4); #2 check("R8 fall ignored in rising mode", nmi0, 0);
    @(negedge clk); nmi_in = 1;
    wait_n(4); #2 check("R8 rising edge latched", nmi0, 1);
    @(negedge clk); nmi_ack = 1;
    @(negedge clk); nmi_ack = 0;

    // R9 variant without flag register
    wr(3'd0, 8'hFF);
    @(negedge clk); irq_in[4] = 0;
    wait_n(4); #2
    check("R9 level line keeps requesting", req1, 1);
    check("R9 level line index", idx1, 4);
    rd(3'd3, 1'b1, 8'h00, "R9 flag register reads zero");
    @(negedge clk); irq_in[4] = 1;
    wait_n(4); #2 check("R9 request drops with line", req1, 0);
    @(negedge clk); irq_in[2] = 0;
    wait_n(2); @(negedge clk); irq_in[2] = 1;
    wait_n(5); #2 check("R9 edge request not held", req1, 0);

    // randomised phase, judged by the model every cycle
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) irq_in = 8'($urandom);
      if ($urandom_range(0, 5) == 0) nmi_in = ~nmi_in;
      nmi_ack  = ($urandom_range(0, 7) == 0);
      reg_we   = ($urandom_range(0, 5) == 0);
      reg_addr = 3'($urandom_range(0, 7));
      reg_wdata = 8'($urandom);
    end
    @(negedge clk); reg_we = 0; nmi_ack = 0;
    wait_n(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule